// File: doc/BRIEF.md
# Debug Trigger and Trace Capture Controller

This block watches a processor bus for accesses to two programmable addresses. Two comparators, A and B, look at each bus access. Each one can be limited to reads only or to writes only, or left open to both directions. A match can raise a trigger event in one of two ways. In force mode it fires on the access itself. In tag mode the match is recorded only when it happens on an opcode fetch, and the trigger fires later, when the processor reports that the opcode at that address has actually executed. A pipeline flush drops any pending tag without a trigger.

The trigger drives a trace buffer of DEPTH entries (8 by default) that records the address of every valid bus access. In begin-trace mode recording starts with the triggering cycle and stops when the buffer fills. In end-trace mode the buffer records continuously, overwriting the oldest entry, and the trigger cycle is the last one stored. Either way, when capture ends the run disarms itself and reports done. A small register port selects the mode and arms a run. While a run is armed, writes to the configuration are locked out.

Top module: `dbg_trig_top`

## Requirements
- R1: After reset every register reads 0. The trigger register always reads bits 5:4 as 0, even after a write of 0xFF while disarmed (that write reads back 0xCF).
- R2: Qualifier register (address 1) fields: bit 0 enables direction checking for A, bit 1 selects the direction for A, bit 2 enables it for B, bit 3 selects it for B. The select bit means 1 = reads only, 0 = writes only. With the enable bit at 0, the bus_rd level has no effect on that comparator.
- R3: In force mode (trigger register bit 7 = 0), an armed run raises trig_evt in the same cycle as a qualifying access. trig_evt never rises while the run is disarmed.
- R4: In tag mode (bit 7 = 1), a qualifying access with bus_fetch = 1 marks its comparator pending, and trig_evt rises when exec_valid reports that same address. An access without a fetch, or an execute with nothing pending, does not trigger. A flush clears pending tags with no trigger.
- R5: Trigger-mode field (bits 3:0): code 0 lets only comparator A trigger; every other code lets A or B trigger.
- R6: Begin-trace mode (bit 6 = 1) stores nothing before the trigger. It stores the trigger cycle's access and each later valid access, and ends when DEPTH entries are held.
- R7: End-trace mode (bit 6 = 0) stores every valid access while armed. Once full it overwrites the oldest entry, and the count holds at DEPTH. The trigger cycle's access is stored last and ends the capture.
- R8: With trigger-mode code 0, bit 6 is ignored and the run behaves as begin-trace.
- R9: The trigger and qualifier registers can be read at any time. Writes to them are ignored while armed.
- R10: Run register (address 2) reads {armed, done, 0, 0, count[3:0]}. Writing bit 7 = 1 while disarmed arms the run and clears done and the count. Writing bit 7 = 0 disarms. Ending a capture clears armed and sets done.
- R11: trc_data shows the stored entry at position trc_idx, where index 0 is the oldest held entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 trigger, 1 qualifier, 2 run |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| cmp_a_addr | input | AW | Comparator A address |
| cmp_b_addr | input | AW | Comparator B address |
| bus_valid | input | 1 | Bus access this cycle |
| bus_addr | input | AW | Bus access address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_fetch | input | 1 | Access is an opcode fetch |
| exec_valid | input | 1 | An opcode completes execution this cycle |
| exec_addr | input | AW | Address of the executed opcode |
| flush | input | 1 | Pipeline flush, drops pending tags |
| trig_evt | output | 1 | Trigger accepted this cycle |
| trc_idx | input | PW | Trace read index, 0 = oldest |
| trc_data | output | AW | Trace entry at trc_idx |
| trc_done | output | 1 | Capture finished |

## Verification
A wrong direction qualifier or mode decode shows up on trig_evt in the same cycle as the access. A lost or stuck tag shows up on the execute cycle that follows the fetch. Errors in the write pointer or count appear in the run register one cycle after the access that was stored. Errors in wrap-around or oldest-first ordering appear only once the buffer has filled and is read back through trc_idx. For that reason the bench overfills the buffer in end-trace mode and reads every slot.

// File: rtl/dbg_trig_pkg.sv
`timescale 1ns/1ps
// Package: shared register layouts and mode codes for the trigger controller.
// Assumes an 8-bit register port.
package dbg_trig_pkg;
    typedef enum logic [1:0] {
        SEL_TRIG = 2'd0,
        SEL_QUAL = 2'd1,
        SEL_RUN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       tag;
        logic       begin_sel;
        logic [1:0] rsvd;
        logic [3:0] mode;
    } trig_cfg_t;

    typedef struct packed {
        logic rd_sel;
        logic dir_en;
    } dir_cfg_t;

    typedef struct packed {
        logic [3:0] rsvd;
        dir_cfg_t   b;
        dir_cfg_t   a;
    } qual_cfg_t;

    localparam logic [7:0] TRIG_WMASK  = 8'hCF;
    localparam logic [7:0] QUAL_WMASK  = 8'h0F;
    localparam logic [3:0] MODE_A_ONLY = 4'd0;
endpackage

// File: rtl/dbg_addr_cmp.sv
`timescale 1ns/1ps
// Address comparator with optional bus-direction qualification.
// Purely combinational; the caller registers any state.
module dbg_addr_cmp
    import dbg_trig_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic [AW-1:0] cmp_addr,
    input  dir_cfg_t      cfg,
    output logic          hit
);
    logic dir_ok;

    // Direction passes when checking is disabled or the level matches.
    always_comb dir_ok = !cfg.dir_en || (bus_rd == cfg.rd_sel);

    // A match needs a valid access at the programmed address.
    always_comb hit = bus_valid && (bus_addr == cmp_addr) && dir_ok;
endmodule

// File: rtl/dbg_tag_track.sv
`timescale 1ns/1ps
// Opcode tag tracker: one pending flag per comparator, set by a fetch that
// matches and consumed by the execute report for the same address.
// Assumes that at most one fetch per comparator is in flight.
module dbg_tag_track #(
    parameter int NCMP = 2,
    parameter int AW   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [NCMP-1:0]          fetch_hit,
    input  logic [NCMP-1:0][AW-1:0]  cmp_addr,
    input  logic                     exec_valid,
    input  logic [AW-1:0]            exec_addr,
    input  logic                     flush,
    output logic                     exec_hit
);
    logic [NCMP-1:0] pend_q;
    logic [NCMP-1:0] exec_match;
    logic [NCMP-1:0] fire;

    for (genvar i = 0; i < NCMP; i++) begin : g_tag
        // Executed address equals this comparator's address.
        always_comb exec_match[i] = exec_valid && (exec_addr == cmp_addr[i]);

        // Pending tag that executes fires unless flushed this cycle.
        always_comb fire[i] = pend_q[i] && exec_match[i] && !flush;

        // Pending flag: flush and disable clear it; fetch sets; execute consumes.
        always_ff @(posedge clk) begin
            if (!rst_n)                 pend_q[i] <= 1'b0;
            else if (!enable || flush)  pend_q[i] <= 1'b0;
            else if (fetch_hit[i])      pend_q[i] <= 1'b1;
            else if (exec_match[i])     pend_q[i] <= 1'b0;
        end
    end

    // Any comparator firing is a tag trigger.
    always_comb exec_hit = |fire;
endmodule

// File: rtl/dbg_trace_buf.sv
`timescale 1ns/1ps
// Circular trace buffer with write pointer and saturating count.
// Assumes DEPTH is a power of two; a full write overwrites the oldest entry.
module dbg_trace_buf #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Entry storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Write pointer advances on each write, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) wr_ptr <= '0;
        else if (wr_en)      wr_ptr <= wr_ptr + 1'b1;
    end

    // Entry count saturates at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                    count <= '0;
        else if (wr_en && count != CW'(DEPTH))  count <= count + 1'b1;
    end

    // Oldest entry sits count places behind the write pointer.
    always_comb rd_ptr = wr_ptr - PW'(count) + rd_idx;
    always_comb rd_data = mem[rd_ptr];
endmodule

// File: rtl/dbg_trig_top.sv
`timescale 1ns/1ps
// Debug trigger and trace capture controller: two address comparators, force
// or tag triggering, begin or end trace into a circular buffer, and a small
// register port whose configuration locks while a run is armed.
// Assumes one register access per cycle and DEPTH of at most 8.
module dbg_trig_top
    import dbg_trig_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NCMP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [AW-1:0] cmp_a_addr,
    input  logic [AW-1:0] cmp_b_addr,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_fetch,
    input  logic          exec_valid,
    input  logic [AW-1:0] exec_addr,
    input  logic          flush,
    output logic          trig_evt,
    input  logic [PW-1:0] trc_idx,
    output logic [AW-1:0] trc_data,
    output logic          trc_done
);
    reg_sel_e                  sel;
    trig_cfg_t                 trig_q;
    qual_cfg_t                 qual_q;
    logic                      armed_q;
    logic                      done_q;
    logic                      capturing_q;
    logic [NCMP-1:0][AW-1:0]   cmp_addr;
    dir_cfg_t [NCMP-1:0]       dir_cfg;
    logic [NCMP-1:0]           hit;
    logic [NCMP-1:0]           hit_use;
    logic                      use_b;
    logic                      eff_begin;
    logic                      tag_trig;
    logic                      trig_raw;
    logic                      wr_en;
    logic                      finish;
    logic                      run_wr;
    logic                      arm_start;
    logic                      disarm;
    logic [CW-1:0]             count;

    // Register select decode.
    always_comb sel = reg_sel_e'(reg_addr);

    // Comparator inputs gathered into arrays.
    always_comb begin
        cmp_addr[0] = cmp_a_addr;
        cmp_addr[1] = cmp_b_addr;
        dir_cfg[0]  = qual_q.a;
        dir_cfg[1]  = qual_q.b;
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        dbg_addr_cmp #(.AW(AW)) u_cmp (
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_rd    (bus_rd),
            .cmp_addr  (cmp_addr[i]),
            .cfg       (dir_cfg[i]),
            .hit       (hit[i])
        );
    end

    // Mode code 0 uses A only; any other code also admits B.
    always_comb use_b = (trig_q.mode != MODE_A_ONLY);
    always_comb hit_use = {hit[1] && use_b, hit[0]};
    // Event-only code forces begin-trace.
    always_comb eff_begin = trig_q.begin_sel || (trig_q.mode == MODE_A_ONLY);

    dbg_tag_track #(.NCMP(NCMP), .AW(AW)) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (armed_q && trig_q.tag),
        .fetch_hit  (hit_use & {NCMP{bus_fetch}}),
        .cmp_addr   (cmp_addr),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr),
        .flush      (flush),
        .exec_hit   (tag_trig)
    );

    // Trigger source by type; accepted only while armed and not yet capturing.
    always_comb trig_raw = trig_q.tag ? tag_trig : (|hit_use);
    always_comb trig_evt = armed_q && !capturing_q && trig_raw;

    // Store in end mode always, in begin mode from the trigger onward.
    always_comb wr_en = armed_q && bus_valid && (!eff_begin || capturing_q || trig_evt);

    // Capture ends on trigger (end mode) or on the filling write (begin mode).
    always_comb finish = armed_q && (eff_begin ? (wr_en && count == CW'(DEPTH - 1))
                                               : trig_evt);

    // Run register write decode.
    always_comb begin
        run_wr    = reg_wr && (sel == SEL_RUN);
        arm_start = run_wr && reg_wdata[7] && !armed_q;
        disarm    = run_wr && !reg_wdata[7];
    end

    // Configuration registers, writable only while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            qual_q <= '0;
        end else if (reg_wr && !armed_q) begin
            if (sel == SEL_TRIG) trig_q <= trig_cfg_t'(reg_wdata & TRIG_WMASK);
            if (sel == SEL_QUAL) qual_q <= qual_cfg_t'(reg_wdata & QUAL_WMASK);
        end
    end

    // Arm bit: completion clears it, software sets or clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (finish)    armed_q <= 1'b0;
        else if (run_wr)    armed_q <= reg_wdata[7];
    end

    // Done flag: set by completion, cleared when a new run is armed.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (arm_start)  done_q <= 1'b0;
        else if (finish)     done_q <= 1'b1;
    end

    // Begin-trace capture window, open from trigger until the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                            capturing_q <= 1'b0;
        else if (!armed_q || finish || disarm) capturing_q <= 1'b0;
        else if (trig_evt && eff_begin)        capturing_q <= 1'b1;
    end

    dbg_trace_buf #(.DEPTH(DEPTH), .DW(AW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (arm_start),
        .wr_en   (wr_en),
        .wr_data (bus_addr),
        .rd_idx  (trc_idx),
        .rd_data (trc_data),
        .count   (count)
    );

    // Register read mux.
    always_comb begin
        unique case (sel)
            SEL_TRIG: reg_rdata = trig_q;
            SEL_QUAL: reg_rdata = qual_q;
            SEL_RUN:  reg_rdata = {armed_q, done_q, 2'b00, 4'(count)};
            default:  reg_rdata = 8'h00;
        endcase
    end

    always_comb trc_done = done_q;
endmodule

// File: rtl/dbg_trig_chk.sv
`timescale 1ns/1ps
// Checker for dbg_trig_top: run-state invariants, bound into every instance.
module dbg_trig_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          armed,
    input logic          done,
    input logic          capturing,
    input logic          trig_evt,
    input logic [CW-1:0] count,
    input logic [7:0]    trig_cfg,
    input logic [7:0]    qual_cfg
);
    // R7
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3
    trig_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |-> armed);
    // R10
    done_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !armed);
    // R10
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(armed));
    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(armed) |-> ($stable(trig_cfg) && $stable(qual_cfg)));
    // R6
    capture_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capturing |-> armed);
endmodule

bind dbg_trig_top dbg_trig_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed_q),
    .done      (done_q),
    .capturing (capturing_q),
    .trig_evt  (trig_evt),
    .count     (count),
    .trig_cfg  (trig_q),
    .qual_cfg  (qual_q)
);

// File: tb/dbg_trig_top_bench.sv
`timescale 1ns/1ps
module dbg_trig_top_bench;
    localparam int AW = 16;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] cmp_a_addr = 16'h0100;
    logic [AW-1:0] cmp_b_addr = 16'h0200;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_fetch = 1'b0;
    logic          exec_valid = 1'b0;
    logic [AW-1:0] exec_addr = '0;
    logic          flush = 1'b0;
    logic          trig_evt;
    logic [PW-1:0] trc_idx = '0;
    logic [AW-1:0] trc_data;
    logic          trc_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dbg_trig_top u_dbg_trig_top (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bus(input logic [15:0] a, input logic rd, input logic fch, output logic t);
        bus_valid = 1'b1; bus_addr = a; bus_rd = rd; bus_fetch = fch;
        #1;
        t = trig_evt;
        tick();
        bus_valid = 1'b0; bus_fetch = 1'b0;
    endtask

    task automatic exe(input logic [15:0] a, output logic t);
        exec_valid = 1'b1; exec_addr = a;
        #1;
        t = trig_evt;
        tick();
        exec_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rreg(2'd0, d); chk("R1 trig reg", d, 8'h00);
        rreg(2'd1, d); chk("R1 qual reg", d, 8'h00);
        rreg(2'd2, d); chk("R1 run reg", d, 8'h00);
        chk("R1 done pin", trc_done, 0);
        wreg(2'd0, 8'hFF);
        rreg(2'd0, d); chk("R1 bits 5:4 zero", d, 8'hCF);
    endtask

    task automatic t_qual();
        logic t;
        wreg(2'd0, 8'h41);
        wreg(2'd1, 8'h03);
        wreg(2'd2, 8'h80);
        bus(16'h0100, 1'b0, 1'b0, t); chk("R2 A write blocked", t, 0);
        bus(16'h0100, 1'b1, 1'b0, t); chk("R2 A read matches (R3 same cycle)", t, 1);
        wreg(2'd2, 8'h00);
        wreg(2'd1, 8'h04);
        wreg(2'd2, 8'h80);
        bus(16'h0200, 1'b1, 1'b0, t); chk("R2 B read blocked", t, 0);
        bus(16'h0200, 1'b0, 1'b0, t); chk("R2 B write matches", t, 1);
        wreg(2'd2, 8'h00);
        bus(16'h0100, 1'b0, 1'b0, t); chk("R3 no trigger disarmed", t, 0);
        wreg(2'd1, 8'h00);
        wreg(2'd2, 8'h80);
        bus(16'h0200, 1'b1, 1'b0, t); chk("R2 B direction ignored", t, 1);
        wreg(2'd2, 8'h00);
        wreg(2'd0, 8'h40);
        wreg(2'd2, 8'h80);
        bus(16'h0200, 1'b1, 1'b0, t); chk("R5 code 0 ignores B", t, 0);
        bus(16'h0100, 1'b1, 1'b0, t); chk("R5 code 0 uses A", t, 1);
        wreg(2'd2, 8'h00);
    endtask

    task automatic t_tag();
        logic t;
        wreg(2'd0, 8'hC1);
        wreg(2'd2, 8'h80);
        bus(16'h0100, 1'b1, 1'b0, t); chk("R4 plain access no trigger", t, 0);
        exe(16'h0100, t); chk("R4 exec without tag", t, 0);
        bus(16'h0100, 1'b1, 1'b1, t); chk("R4 fetch no immediate trigger", t, 0);
        flush = 1'b1; tick(); flush = 1'b0;
        exe(16'h0100, t); chk("R4 flush drops tag", t, 0);
        bus(16'h0200, 1'b1, 1'b1, t);
        exe(16'h0200, t); chk("R4 tagged exec triggers", t, 1);
        wreg(2'd2, 8'h00);
    endtask

    task automatic t_begin();
        logic t;
        logic [7:0] d;
        wreg(2'd0, 8'h41);
        wreg(2'd2, 8'h80);
        bus(16'h0010, 1'b1, 1'b0, t);
        bus(16'h0011, 1'b1, 1'b0, t);
        rreg(2'd2, d); chk("R6 nothing before trigger", d, 8'h80);
        bus(16'h0100, 1'b1, 1'b0, t);
        for (int i = 0; i < 7; i++) bus(16'h0020 + 16'(i), 1'b1, 1'b0, t);
        rreg(2'd2, d); chk("R6 R10 full ends run", d, 8'h48);
        chk("R10 done pin", trc_done, 1);
        bus(16'h0100, 1'b1, 1'b0, t); chk("R10 disarmed after finish", t, 0);
        rreg(2'd2, d); chk("R6 count holds after finish", d, 8'h48);
        trc_idx = 0; #1; chk("R11 R6 oldest is trigger access", trc_data, 16'h0100);
        for (int i = 1; i < 8; i++) begin
            trc_idx = PW'(i); #1;
            chk("R11 begin order", trc_data, 16'h0020 + i - 1);
        end
    endtask

    task automatic t_end();
        logic t;
        logic [7:0] d;
        wreg(2'd0, 8'h01);
        wreg(2'd2, 8'h80);
        rreg(2'd2, d); chk("R10 arm clears done and count", d, 8'h80);
        for (int i = 0; i < 12; i++) bus(16'h0030 + 16'(i), 1'b0, 1'b0, t);
        rreg(2'd2, d); chk("R7 count saturates, still armed", d, 8'h88);
        bus(16'h0200, 1'b1, 1'b0, t); chk("R7 trigger", t, 1);
        rreg(2'd2, d); chk("R7 R10 trigger ends run", d, 8'h48);
        for (int i = 0; i < 7; i++) begin
            trc_idx = PW'(i); #1;
            chk("R7 R11 wrap order", trc_data, 16'h0035 + i);
        end
        trc_idx = 7; #1; chk("R7 trigger stored last", trc_data, 16'h0200);
    endtask

    task automatic t_override_lock();
        logic t;
        logic [7:0] d;
        wreg(2'd0, 8'h00);
        wreg(2'd2, 8'h80);
        bus(16'h0030, 1'b0, 1'b0, t);
        rreg(2'd2, d); chk("R8 code 0 no pre-trigger store", d, 8'h80);
        bus(16'h0100, 1'b0, 1'b0, t); chk("R8 trigger", t, 1);
        rreg(2'd2, d); chk("R8 begin forced", d, 8'h81);
        wreg(2'd0, 8'hC5);
        rreg(2'd0, d); chk("R9 trig write locked", d, 8'h00);
        wreg(2'd1, 8'h0F);
        rreg(2'd1, d); chk("R9 qual write locked", d, 8'h00);
        wreg(2'd2, 8'h00);
        rreg(2'd2, d); chk("R10 disarm", d, 8'h01);
        wreg(2'd0, 8'h85);
        rreg(2'd0, d); chk("R9 write accepted disarmed", d, 8'h85);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_qual();
        t_tag();
        t_begin();
        t_end();
        t_override_lock();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule